// File: doc/BRIEF.md
# Three-Line Event Interrupt Aggregator

This block collects 96 one-cycle event strobes from peripherals into three 32-bit pending words. Each event has a fixed home: word index equals the event number divided by 32, and bit position equals the event number modulo 32. A pending bit stays set until software clears it by writing a 1 to it. The pending words are shared, but each of the three interrupt lines has its own full bank of three enable words. A line is raised while any pending bit is also enabled in that line's bank.

Line 0 is the most urgent output, line 1 the middle one and line 2 the least urgent. Arbitration between the three lines belongs to the processor. To save the handler a bit scan, the block also gives each line a read-only vector word. The vector names the lowest-numbered event that is both pending and enabled for that line, and a flag says whether there is one. Access is through a simple 32-bit register port with byte addresses. Reads are combinational. Writes take effect at the clock edge.

Top module: `evt_irq_agg`

## Requirements
- R1: After synchronous reset, all three pending words and all nine enable words read as zero. Every interrupt line is low, and every vector word reads zero.
- R2: A strobe on event n sets bit (n mod 32) of pending word (n / 32) at the next clock edge. The bit stays set until it is cleared.
- R3: The pending words are at byte offsets 0x00, 0x04 and 0x08. Writing a 1 to a bit clears it. Writing a 0 leaves the bit unchanged.
- R4: If a strobe and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R5: Enable word w of line g is at offset 0x10·(g+1) + 4·w, for g and w in 0..2. It reads back exactly what was last written.
- R6: irq_out[g] is a register. Its value after a clock edge is the OR, over the three words, of (pending AND line g's enable word) as it stood before that edge. The line therefore rises one clock after its first contributing bit is set.
- R7: Clearing an enable bit drops that event's contribution to the line. The pending bit is not cleared.
- R8: The vector word of line g is at offset 0x40 + 4·g. Bits [6:0] hold the lowest global event number (word·32 + bit) that is pending and enabled for line g. Bit 31 is 1 when such an event exists. All other bits are 0, and the whole word is 0 when no event qualifies.
- R9: The following read as zero, and writes to them change nothing: the vector words (read-only), unmapped offsets, and addresses with bits [1:0] not zero. reg_rd_data is zero whenever reg_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | 32 | Combinational read data |
| evt_strobe | input | 96 | One-cycle event pulses, bit n is event n |
| irq_out | output | 3 | Level interrupt lines, index 0 most urgent |

## Verification
Directed cases cover the following:
- A single event with no enables, which shows that a pending bit alone does not raise a line.
- Enabling that event on one line, which shows the one-clock delay of the line.
- Two events enabled on the same line, which checks that the vector picks the lower number.
- Event 95 on the least urgent line, which checks the top edge of the numbering.
- A strobe colliding with its own clear, and zero writes.
- Writes to holes, to the vector words and to misaligned addresses. Each of these would show up as a changed read-back.

A seeded random phase then mixes sparse strobe patterns with writes to mapped and unmapped offsets. After every cycle it compares each line against a bench model, and it periodically compares every register. This separates wrong word/bit placement, wrong bank selection and lost clears.

// File: rtl/evt_irq_agg_pkg.sv
package evt_irq_agg_pkg;

    localparam int REG_ADDR_W   = 8;
    localparam int REG_DATA_W   = 32;
    localparam int DEF_WORDS    = 3;
    localparam int DEF_LINES    = 3;
    localparam int GRP_FIELD_W  = REG_ADDR_W - 4;

    typedef enum logic [1:0] {
        SEL_PENDING,
        SEL_ENABLE,
        SEL_VECTOR,
        SEL_NONE
    } reg_region_e;

    typedef struct packed {
        reg_region_e            region;
        logic [GRP_FIELD_W-1:0] group;
        logic [1:0]             word;
    } reg_sel_t;

    // Byte address map: bits [1:0] must be zero, bits [3:2] pick the word,
    // bits [7:4] pick the region: 0 pending, 1..n_lines enable banks, n_lines+1 vectors.
    function automatic reg_sel_t decode_addr(input logic [REG_ADDR_W-1:0] addr,
                                             input int n_words,
                                             input int n_lines);
        reg_sel_t s;
        int       hi;
        s.region = SEL_NONE;
        s.group  = '0;
        s.word   = addr[3:2];
        hi       = int'(addr[REG_ADDR_W-1:4]);
        if (addr[1:0] == 2'b00 && int'(addr[3:2]) < n_words) begin
            if (hi == 0) begin
                s.region = SEL_PENDING;
            end else if (hi <= n_lines) begin
                s.region = SEL_ENABLE;
                s.group  = addr[REG_ADDR_W-1:4] - GRP_FIELD_W'(1);
            end else if (hi == n_lines + 1 && int'(addr[3:2]) < n_lines) begin
                s.region = SEL_VECTOR;
                s.group  = GRP_FIELD_W'(addr[3:2]);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/evt_pending_bank.sv
module evt_pending_bank #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    localparam int TOTAL    = NUM_WORDS * WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TOTAL-1:0] evt_set,
    input  logic [TOTAL-1:0] clr_req,
    output logic [TOTAL-1:0] pending
);

    logic [TOTAL-1:0] pending_q;

    always_ff @(posedge clk) begin
        if (rst) pending_q <= '0;
        else     pending_q <= (pending_q & ~clr_req) | evt_set;
    end

    assign pending = pending_q;

    // R2 / R4: a strobed bit is set after the edge, even if a clear hit it too
    p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_set != '0) |=> ((pending_q & $past(evt_set)) == $past(evt_set)));

    // R3: a bit only drops when a clear was requested for it
    p_no_silent_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_req == '0) |=> ((pending_q & $past(pending_q)) == $past(pending_q)));

endmodule

// File: rtl/evt_line_unit.sv
module evt_line_unit #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    localparam int TOTAL    = NUM_WORDS * WORD_W,
    localparam int IDX_W    = $clog2(TOTAL)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WORDS-1:0] wr_word,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [TOTAL-1:0]     pending,
    output logic [TOTAL-1:0]     enable,
    output logic                 irq,
    output logic                 vec_valid,
    output logic [IDX_W-1:0]     vec_idx
);

    logic [TOTAL-1:0] masked;
    logic             irq_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_en_word
        logic [WORD_W-1:0] en_q;
        always_ff @(posedge clk) begin
            if (rst)             en_q <= '0;
            else if (wr_word[w]) en_q <= wr_data;
        end
        assign enable[w*WORD_W +: WORD_W] = en_q;
    end

    assign masked = pending & enable;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked;
    end

    assign irq = irq_q;

    // Lowest set bit wins: scan downward so the last hit is the smallest index
    always_comb begin
        vec_valid = 1'b0;
        vec_idx   = '0;
        for (int i = TOTAL - 1; i >= 0; i--) begin
            if (masked[i]) begin
                vec_valid = 1'b1;
                vec_idx   = IDX_W'(i);
            end
        end
    end

    // R6: line follows the masked pending set with one register of delay
    p_line_rises_r6: assert property (@(posedge clk) disable iff (rst)
        (masked != '0) |=> irq_q);
    p_line_falls_r6: assert property (@(posedge clk) disable iff (rst)
        (masked == '0) |=> !irq_q);

    // R8: vector points at a qualifying event, and is invalid only when none exists
    p_vec_hit_r8: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (pending[vec_idx] && enable[vec_idx]));
    p_vec_empty_r8: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> ((pending & enable) == '0));

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
    import evt_irq_agg_pkg::*;
#(
    parameter int NUM_WORDS = DEF_WORDS,
    parameter int NUM_LINES = DEF_LINES,
    parameter int WORD_W    = REG_DATA_W,
    localparam int TOTAL    = NUM_WORDS * WORD_W,
    localparam int IDX_W    = $clog2(TOTAL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr_en,
    input  logic [WORD_W-1:0]     reg_wr_data,
    input  logic                  reg_rd_en,
    output logic [WORD_W-1:0]     reg_rd_data,
    input  logic [TOTAL-1:0]      evt_strobe,
    output logic [NUM_LINES-1:0]  irq_out
);

    reg_sel_t         sel;
    logic [TOTAL-1:0] clr_req;
    logic [TOTAL-1:0] pending;
    logic [TOTAL-1:0] enable_flat [NUM_LINES];
    logic             vec_valid   [NUM_LINES];
    logic [IDX_W-1:0] vec_idx     [NUM_LINES];

    assign sel = decode_addr(reg_addr, NUM_WORDS, NUM_LINES);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
        assign clr_req[w*WORD_W +: WORD_W] =
            (reg_wr_en && sel.region == SEL_PENDING && int'(sel.word) == w)
            ? reg_wr_data : '0;
    end

    evt_pending_bank #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) u_pending (
        .clk     (clk),
        .rst     (rst),
        .evt_set (evt_strobe),
        .clr_req (clr_req),
        .pending (pending)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [NUM_WORDS-1:0] wr_word;
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_we
            assign wr_word[w] = reg_wr_en && sel.region == SEL_ENABLE &&
                                int'(sel.group) == g && int'(sel.word) == w;
        end

        evt_line_unit #(
            .NUM_WORDS (NUM_WORDS),
            .WORD_W    (WORD_W)
        ) u_line (
            .clk       (clk),
            .rst       (rst),
            .wr_word   (wr_word),
            .wr_data   (reg_wr_data),
            .pending   (pending),
            .enable    (enable_flat[g]),
            .irq       (irq_out[g]),
            .vec_valid (vec_valid[g]),
            .vec_idx   (vec_idx[g])
        );
    end

    always_comb begin
        reg_rd_data = '0;
        if (reg_rd_en) begin
            unique case (sel.region)
                SEL_PENDING: reg_rd_data = pending[int'(sel.word)*WORD_W +: WORD_W];
                SEL_ENABLE:  reg_rd_data = enable_flat[int'(sel.group)][int'(sel.word)*WORD_W +: WORD_W];
                SEL_VECTOR:  reg_rd_data = {vec_valid[int'(sel.group)],
                                            {(WORD_W-1-IDX_W){1'b0}},
                                            vec_idx[int'(sel.group)]};
                default:     reg_rd_data = '0;
            endcase
        end
    end

    // R9: read port is quiet when not strobed
    p_rd_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |-> (reg_rd_data == '0));

    // R1: lines are low in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (irq_out == '0));

endmodule

// File: tb/evt_irq_agg_tb.sv
`timescale 1ns/1ps
module evt_irq_agg_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic        reg_rd_en;
    logic [31:0] reg_rd_data;
    logic [95:0] evt_strobe;
    logic [2:0]  irq_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_pend [3];
    logic [31:0] m_en   [3][3];
    logic [2:0]  m_irq;

    always #4 clk = ~clk;

    evt_irq_agg u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_data (reg_rd_data),
        .evt_strobe  (evt_strobe),
        .irq_out     (irq_out)
    );

    function automatic logic [2:0] model_lines();
        logic [2:0] r = '0;
        for (int g = 0; g < 3; g++)
            for (int w = 0; w < 3; w++)
                if ((m_pend[w] & m_en[g][w]) != 0) r[g] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] model_vec(input int g);
        for (int n = 0; n < 96; n++)
            if (m_pend[n/32][n%32] && m_en[g][n/32][n%32])
                return 32'h8000_0000 | 32'(n);
        return 32'h0;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int w;
        int g;
        if (a[1:0] != 2'b00) return 32'h0;
        w = int'(a[3:2]);
        if (w > 2) return 32'h0;
        if (a[7:4] == 4'h0) return m_pend[w];
        if (a[7:4] >= 4'h1 && a[7:4] <= 4'h3) begin
            g = int'(a[7:4]) - 1;
            return m_en[g][w];
        end
        if (a[7:4] == 4'h4) return model_vec(w);
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive, clock edge, update model, check lines
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [95:0] ev);
        @(negedge clk);
        reg_wr_en   = wr;
        reg_addr    = a;
        reg_wr_data = d;
        evt_strobe  = ev;
        @(posedge clk);
        m_irq = model_lines();
        if (wr && a[1:0] == 2'b00 && a[3:2] != 2'b11) begin
            if (a[7:4] == 4'h0) m_pend[a[3:2]] &= ~d;
            else if (a[7:4] >= 4'h1 && a[7:4] <= 4'h3) m_en[int'(a[7:4])-1][a[3:2]] = d;
        end
        for (int n = 0; n < 96; n++)
            if (ev[n]) m_pend[n/32][n%32] = 1'b1;
        #1;
        reg_wr_en  = 1'b0;
        evt_strobe = '0;
        check("R6 line levels", {29'h0, irq_out}, {29'h0, m_irq});
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr  = a;
        reg_rd_en = 1'b1;
        #1;
        check(req, reg_rd_data, exp);
        reg_rd_en = 1'b0;
    endtask

    task automatic rd_all(input string req);
        for (int i = 0; i < 20; i++) begin
            logic [7:0] a = 8'(i * 4);
            rd(req, a, model_read(a));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed        = 32'd5171;
        void'($urandom(seed));
        rst         = 1'b1;
        reg_addr    = '0;
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
        reg_rd_en   = 1'b0;
        evt_strobe  = '0;
        for (int w = 0; w < 3; w++) begin
            m_pend[w] = '0;
            for (int g = 0; g < 3; g++) m_en[g][w] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check("R1 lines after reset", {29'h0, irq_out}, 32'h0);
        rd_all("R1 reset readback");

        // R2: event 37 -> word 1 bit 5, no enable so no line
        step(1'b0, 8'h00, 32'h0, 96'h1 << 37);
        rd("R2 event 37 placement", 8'h04, 32'h0000_0020);
        step(1'b0, 8'h00, 32'h0, '0);
        check("R2 pending alone keeps lines low", {29'h0, irq_out}, 32'h0);

        // R5/R6: enable on line 1, line rises one clock later
        step(1'b1, 8'h24, 32'h0000_0020, '0);
        check("R6 line 1 not yet up", {31'h0, irq_out[1]}, 32'h0);
        step(1'b0, 8'h00, 32'h0, '0);
        check("R6 line 1 up after one clock", {31'h0, irq_out[1]}, 32'h1);
        rd("R5 enable readback 0x24", 8'h24, 32'h0000_0020);
        rd("R8 vector line 1 event 37", 8'h44, 32'h8000_0025);

        // R8: lower event on same line takes the vector
        step(1'b0, 8'h00, 32'h0, 96'h1 << 3);
        step(1'b1, 8'h20, 32'h0000_0008, '0);
        rd("R8 vector picks lowest", 8'h44, 32'h8000_0003);

        // R7: drop enable, pending kept
        step(1'b1, 8'h24, 32'h0, '0);
        step(1'b1, 8'h20, 32'h0, '0);
        step(1'b0, 8'h00, 32'h0, '0);
        check("R7 line 1 down", {31'h0, irq_out[1]}, 32'h0);
        rd("R7 pending word 1 kept", 8'h04, 32'h0000_0020);
        rd("R7 vector empty", 8'h44, 32'h0);

        // R3: zero write keeps, one write clears
        step(1'b1, 8'h04, 32'h0, '0);
        rd("R3 zero write keeps", 8'h04, 32'h0000_0020);
        step(1'b1, 8'h04, 32'h0000_0020, '0);
        rd("R3 one write clears", 8'h04, 32'h0);

        // R4: strobe and clear on the same bit
        step(1'b1, 8'h00, 32'h0000_0008, 96'h1 << 3);
        rd("R4 event beats clear", 8'h00, 32'h0000_0008);

        // R8 boundary: event 95 on line 2
        step(1'b1, 8'h38, 32'h8000_0000, 96'h1 << 95);
        step(1'b0, 8'h00, 32'h0, '0);
        check("R8 line 2 up for event 95", {31'h0, irq_out[2]}, 32'h1);
        rd("R8 vector event 95", 8'h48, 32'h8000_005F);

        // R9: holes, vectors and misaligned addresses ignore writes
        step(1'b1, 8'h0C, 32'hFFFF_FFFF, '0);
        step(1'b1, 8'h3C, 32'hFFFF_FFFF, '0);
        step(1'b1, 8'h48, 32'h0, '0);
        step(1'b1, 8'h39, 32'h0, '0);
        step(1'b1, 8'h02, 32'hFFFF_FFFF, '0);
        rd("R9 hole 0x0C reads zero", 8'h0C, 32'h0);
        rd("R9 hole 0x4C reads zero", 8'h4C, 32'h0);
        rd("R9 misaligned reads zero", 8'h39, 32'h0);
        rd("R9 vector unchanged by write", 8'h48, 32'h8000_005F);
        rd("R9 enable unchanged by misaligned write", 8'h38, 32'h8000_0000);
        rd("R9 pending unchanged by misaligned write", 8'h00, 32'h0000_0008);
        @(negedge clk);
        reg_addr = 8'h00;
        #1 check("R9 idle read data", reg_rd_data, 32'h0);

        // Random phase
        for (int c = 0; c < 600; c++) begin
            logic [95:0] ev;
            logic [7:0]  a;
            logic        wr;
            ev = {$urandom & $urandom & $urandom & $urandom,
                  $urandom & $urandom & $urandom & $urandom,
                  $urandom & $urandom & $urandom & $urandom};
            if ($urandom % 3 == 0) ev = '0;
            wr = ($urandom % 2) == 1;
            a  = 8'(($urandom % 21) * 4);
            if ($urandom % 10 == 0) a = 8'($urandom);
            step(wr, a, $urandom, ev);
            if (c % 40 == 39) rd_all("R2 R3 R5 R8 random readback");
        end
        rd_all("R8 final readback");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule